// File: doc/BRIEF.md
# Label Root Table with Single-Cycle Merge

This block keeps, for every temporary label a streaming connected-region labeller can hand out, the label that currently represents that label's region (its root). A pixel labeller reads the roots of up to four neighbour labels in the same cycle through independent combinational lookup ports. When it finds that two labels touch the same region, it issues one merge command. In a single clock edge the table then redirects every label that pointed at the losing root to the surviving root.

The table never holds chains. Every entry always names a final root, so one lookup is enough and no pointer walk is ever needed. A frame-start initialisation puts every entry back to pointing at itself in one cycle. The merge command answers with a one-cycle done flag, so the caller can pace its feature merging against it.

Top module: `label_root_table`

## Requirements
- R1: While reset is held and after it is released, every entry holds its own index, so a lookup of label k returns k.
- R2: A cycle with `init_i` high rewrites every entry to its own index; lookups in the following cycle return their own address.
- R3: Each of the `RD_PORTS` lookup ports returns the current root of its address combinationally in the same cycle, independently of the other ports, including when several ports use the same address.
- R4: On a merge of labels A and B whose roots differ, the smaller of the two roots survives. Every entry equal to the larger root is rewritten to the smaller root, all at one clock edge, and after that edge no entry holds the larger root.
- R5: The order of the two merge operands has no effect: merging (A, B) gives the same table as merging (B, A).
- R6: A merge of two labels that already share a root leaves every entry unchanged.
- R7: `merge_done_o` is high for exactly the one cycle after each accepted merge, whether or not it changed the table, and low otherwise.
- R8: When `init_i` and `merge_valid_i` are high in the same cycle, the initialisation wins. The merge is dropped and `merge_done_o` stays low in the following cycle.
- R9: A lookup in the cycle directly after a merge returns the updated roots.
- R10: At all times each entry's root is no greater than the entry's index, and every root is its own root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Frame-start initialisation of all entries |
| merge_valid_i | input | 1 | Merge command strobe |
| merge_a_i | input | LABEL_W | First label of the merge pair |
| merge_b_i | input | LABEL_W | Second label of the merge pair |
| merge_done_o | output | 1 | One-cycle acknowledge of an accepted merge |
| rd_addr_i | input | RD_PORTS*LABEL_W | Packed lookup addresses; port p occupies bits [p*LABEL_W +: LABEL_W] |
| rd_root_o | output | RD_PORTS*LABEL_W | Packed roots, same packing as the addresses |

## Verification
The bench builds the table with LABEL_W = 3 and four lookup ports, so eight entries. With that size the whole table can be read in two cycles after every command, and any corruption of an unrelated entry shows up at the ports. The small label space also makes it quick to build the chained four-to-one collapse, a merge whose smaller operand label owns the larger root, and repeated merges that gather three labels under one root. It also reaches no-op merges, swapped operands, and initialisation that collides with a merge.

// File: rtl/leq_pkg.sv
package leq_pkg;

  // What the merge controller decided for the current cycle.
  typedef enum logic [1:0] {
    MRG_IDLE = 2'd0,
    MRG_SAME = 2'd1,
    MRG_JOIN = 2'd2,
    MRG_INIT = 2'd3
  } merge_kind_t;

  // Number of table entries for a label width.
  function automatic int unsigned label_count(input int unsigned width);
    return 32'd1 << width;
  endfunction

endpackage

// File: rtl/leq_read_mux.sv
module leq_read_mux #(
  parameter int unsigned LABEL_W  = 5,
  parameter int unsigned N_LABELS = 32
) (
  input  logic [N_LABELS*LABEL_W-1:0] tab_flat_i,
  input  logic [LABEL_W-1:0]          addr_i,
  output logic [LABEL_W-1:0]          root_o
);

  // Entry k sits at bits [k*LABEL_W +: LABEL_W].
  always_comb begin
    root_o = tab_flat_i[addr_i*LABEL_W +: LABEL_W];
  end

endmodule

// File: rtl/leq_merge_ctrl.sv
module leq_merge_ctrl
  import leq_pkg::*;
#(
  parameter int unsigned LABEL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_i,
  input  logic               merge_valid_i,
  input  logic [LABEL_W-1:0] root_a_i,
  input  logic [LABEL_W-1:0] root_b_i,
  output merge_kind_t        kind_o,
  output logic               fire_o,
  output logic               join_o,
  output logic [LABEL_W-1:0] old_root_o,
  output logic [LABEL_W-1:0] new_root_o,
  output logic               done_o
);

  function automatic logic [LABEL_W-1:0] pick_lo(input logic [LABEL_W-1:0] x,
                                                 input logic [LABEL_W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic [LABEL_W-1:0] pick_hi(input logic [LABEL_W-1:0] x,
                                                 input logic [LABEL_W-1:0] y);
    return (x < y) ? y : x;
  endfunction

  always_comb begin
    if (init_i)                     kind_o = MRG_INIT;
    else if (!merge_valid_i)        kind_o = MRG_IDLE;
    else if (root_a_i == root_b_i)  kind_o = MRG_SAME;
    else                            kind_o = MRG_JOIN;
  end

  assign fire_o     = (kind_o == MRG_SAME) || (kind_o == MRG_JOIN);
  assign join_o     = (kind_o == MRG_JOIN);
  assign new_root_o = pick_lo(root_a_i, root_b_i);
  assign old_root_o = pick_hi(root_a_i, root_b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= fire_o;
  end

endmodule

// File: rtl/leq_entry.sv
module leq_entry #(
  parameter int unsigned LABEL_W = 5,
  parameter int unsigned IDX     = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_i,
  input  logic               join_i,
  input  logic [LABEL_W-1:0] old_root_i,
  input  logic [LABEL_W-1:0] new_root_i,
  output logic [LABEL_W-1:0] root_q
);

  localparam logic [LABEL_W-1:0] SELF = LABEL_W'(IDX);

  // Each entry compares itself against the losing root and redirects.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             root_q <= SELF;
    else if (init_i)                        root_q <= SELF;
    else if (join_i && root_q == old_root_i) root_q <= new_root_i;
  end

endmodule

// File: rtl/label_root_table.sv
module label_root_table
  import leq_pkg::*;
#(
  parameter int unsigned LABEL_W  = 5,
  parameter int unsigned RD_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init_i,
  input  logic                        merge_valid_i,
  input  logic [LABEL_W-1:0]          merge_a_i,
  input  logic [LABEL_W-1:0]          merge_b_i,
  output logic                        merge_done_o,
  input  logic [RD_PORTS*LABEL_W-1:0] rd_addr_i,
  output logic [RD_PORTS*LABEL_W-1:0] rd_root_o
);

  localparam int unsigned N_LABELS = label_count(LABEL_W);

  // Named internal events, brought out for the bound checker.
  logic [N_LABELS*LABEL_W-1:0] tab_flat;
  logic [LABEL_W-1:0]          root_a;
  logic [LABEL_W-1:0]          root_b;
  logic [LABEL_W-1:0]          old_root;
  logic [LABEL_W-1:0]          new_root;
  logic                        merge_fire;
  logic                        merge_join;
  merge_kind_t                 merge_kind;

  // Roots of the two merge operands, sampled before the edge.
  leq_read_mux #(.LABEL_W(LABEL_W), .N_LABELS(N_LABELS)) u_rd_a (
    .tab_flat_i (tab_flat),
    .addr_i     (merge_a_i),
    .root_o     (root_a)
  );

  leq_read_mux #(.LABEL_W(LABEL_W), .N_LABELS(N_LABELS)) u_rd_b (
    .tab_flat_i (tab_flat),
    .addr_i     (merge_b_i),
    .root_o     (root_b)
  );

  leq_merge_ctrl #(.LABEL_W(LABEL_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_i        (init_i),
    .merge_valid_i (merge_valid_i),
    .root_a_i      (root_a),
    .root_b_i      (root_b),
    .kind_o        (merge_kind),
    .fire_o        (merge_fire),
    .join_o        (merge_join),
    .old_root_o    (old_root),
    .new_root_o    (new_root),
    .done_o        (merge_done_o)
  );

  for (genvar e = 0; e < N_LABELS; e++) begin : g_entry
    leq_entry #(.LABEL_W(LABEL_W), .IDX(e)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (init_i),
      .join_i     (merge_join),
      .old_root_i (old_root),
      .new_root_i (new_root),
      .root_q     (tab_flat[e*LABEL_W +: LABEL_W])
    );
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    leq_read_mux #(.LABEL_W(LABEL_W), .N_LABELS(N_LABELS)) u_rd (
      .tab_flat_i (tab_flat),
      .addr_i     (rd_addr_i[p*LABEL_W +: LABEL_W]),
      .root_o     (rd_root_o[p*LABEL_W +: LABEL_W])
    );
  end

endmodule

// File: rtl/leq_checker.sv
module leq_checker
  import leq_pkg::*;
#(
  parameter int unsigned LABEL_W  = 5,
  parameter int unsigned RD_PORTS = 4,
  parameter int unsigned N_LABELS = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        init_i,
  input logic [LABEL_W-1:0]          merge_a_i,
  input logic [LABEL_W-1:0]          merge_b_i,
  input logic                        merge_done_o,
  input logic [RD_PORTS*LABEL_W-1:0] rd_addr_i,
  input logic [RD_PORTS*LABEL_W-1:0] rd_root_o,
  input logic [N_LABELS*LABEL_W-1:0] tab_flat,
  input logic                        merge_fire,
  input logic                        merge_join,
  input logic [LABEL_W-1:0]          old_root,
  input logic [LABEL_W-1:0]          new_root,
  input merge_kind_t                 merge_kind
);

  function automatic logic [LABEL_W-1:0] entry_of(input logic [N_LABELS*LABEL_W-1:0] t,
                                                  input logic [LABEL_W-1:0] k);
    return t[k*LABEL_W +: LABEL_W];
  endfunction

  function automatic logic holds_value(input logic [N_LABELS*LABEL_W-1:0] t,
                                       input logic [LABEL_W-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N_LABELS; k++)
      if (t[k*LABEL_W +: LABEL_W] == v) hit = 1'b1;
    return hit;
  endfunction

  // R7: acknowledge follows every accepted merge.
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    merge_fire |=> merge_done_o);

  // R8: no acknowledge without an accepted merge (init wins).
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge_fire || merge_kind == MRG_INIT) |=> !merge_done_o);

  // R4: both operands share a root after a merge.
  p_pair_joined_r4: assert property (@(posedge clk) disable iff (!rst_n)
    merge_fire |=> entry_of(tab_flat, $past(merge_a_i)) == entry_of(tab_flat, $past(merge_b_i)));

  // R4: the losing root has vanished from the table.
  p_loser_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    merge_join |=> !holds_value(tab_flat, $past(old_root)));

  // R6: no-op merge keeps every entry.
  p_noop_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_fire && !merge_join) |=> $stable(tab_flat));

  for (genvar e = 0; e < N_LABELS; e++) begin : g_ent
    // R2: initialisation restores identity.
    p_init_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> tab_flat[e*LABEL_W +: LABEL_W] == LABEL_W'(e));

    // R10: roots never exceed the index and are fixed points.
    p_root_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tab_flat[e*LABEL_W +: LABEL_W] <= LABEL_W'(e));
    p_root_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      entry_of(tab_flat, tab_flat[e*LABEL_W +: LABEL_W]) == tab_flat[e*LABEL_W +: LABEL_W]);
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_prt
    // R9: a lookup of the old root right after a join sees the survivor.
    p_lookup_after_join_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(merge_join) && !$past(init_i) &&
       rd_addr_i[p*LABEL_W +: LABEL_W] == $past(old_root))
      |-> rd_root_o[p*LABEL_W +: LABEL_W] == $past(new_root));
  end

endmodule

bind label_root_table leq_checker #(
  .LABEL_W  (LABEL_W),
  .RD_PORTS (RD_PORTS),
  .N_LABELS (N_LABELS)
) u_leq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_i       (init_i),
  .merge_a_i    (merge_a_i),
  .merge_b_i    (merge_b_i),
  .merge_done_o (merge_done_o),
  .rd_addr_i    (rd_addr_i),
  .rd_root_o    (rd_root_o),
  .tab_flat     (tab_flat),
  .merge_fire   (merge_fire),
  .merge_join   (merge_join),
  .old_root     (old_root),
  .new_root     (new_root),
  .merge_kind   (merge_kind)
);

// File: tb/label_root_table_tb_top.sv
module label_root_table_tb_top;

  localparam int W  = 3;
  localparam int NP = 4;
  localparam int NL = 1 << W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            init_i = 1'b0;
  logic            merge_valid_i = 1'b0;
  logic [W-1:0]    merge_a_i = '0;
  logic [W-1:0]    merge_b_i = '0;
  logic            merge_done_o;
  logic [NP*W-1:0] rd_addr_i = '0;
  logic [NP*W-1:0] rd_root_o;

  always #4 clk = ~clk;  // 125 MHz

  label_root_table #(.LABEL_W(W), .RD_PORTS(NP)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_i        (init_i),
    .merge_valid_i (merge_valid_i),
    .merge_a_i     (merge_a_i),
    .merge_b_i     (merge_b_i),
    .merge_done_o  (merge_done_o),
    .rd_addr_i     (rd_addr_i),
    .rd_root_o     (rd_root_o)
  );

  typedef struct {
    logic            done;
    logic [NP*W-1:0] roots;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  int   mdl[NL];
  logic prev_fire = 1'b0;
  logic finished = 1'b0;

  // Reference table restated from the requirements.
  task automatic mdl_apply(input logic in_init, input logic mv, input int a, input int b);
    int ra, rb, lo, hi;
    if (in_init) begin
      for (int k = 0; k < NL; k++) mdl[k] = k;
    end else if (mv) begin
      ra = mdl[a]; rb = mdl[b];
      lo = (ra < rb) ? ra : rb;
      hi = (ra < rb) ? rb : ra;
      if (ra != rb)
        for (int k = 0; k < NL; k++) if (mdl[k] == hi) mdl[k] = lo;
    end
  endtask

  // Driver: one cycle of stimulus, expectations pushed to the scoreboard.
  task automatic step(input logic in_init, input logic mv, input int a, input int b,
                      input int p0, input int p1, input int p2, input int p3,
                      input string tag);
    exp_t e;
    int   ad[NP];
    ad[0] = p0; ad[1] = p1; ad[2] = p2; ad[3] = p3;
    @(posedge clk); #1;
    init_i        = in_init;
    merge_valid_i = mv;
    merge_a_i     = W'(a);
    merge_b_i     = W'(b);
    for (int p = 0; p < NP; p++) rd_addr_i[p*W +: W] = W'(ad[p]);
    e.done = prev_fire;
    for (int p = 0; p < NP; p++) e.roots[p*W +: W] = W'(mdl[ad[p]]);
    e.tag = tag;
    exp_q.push_back(e);
    mdl_apply(in_init, mv, a, b);
    prev_fire = mv && !in_init;
  endtask

  task automatic look(input int base, input string tag);
    step(1'b0, 1'b0, 0, 0, base, base + 1, base + 2, base + 3, tag);
  endtask

  task automatic look_all(input string tag);
    look(0, tag);
    look(4, tag);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run++;
      if (merge_done_o !== e.done) begin
        n_fail++;
        $display("FAIL %s done: actual %0b expected %0b", e.tag, merge_done_o, e.done);
      end
      for (int p = 0; p < NP; p++) begin
        n_run++;
        if (rd_root_o[p*W +: W] !== e.roots[p*W +: W]) begin
          n_fail++;
          $display("FAIL %s port%0d addr %0d: actual %0d expected %0d", e.tag, p,
                   rd_addr_i[p*W +: W], rd_root_o[p*W +: W], e.roots[p*W +: W]);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NL; k++) mdl[k] = k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    look_all("R1 reset identity");
    look(0, "R3 distinct ports");
    step(1'b0, 1'b0, 0, 0, 5, 5, 5, 5, "R3 same address on all ports");

    // Chain collapse: 4->3, 3->2, 2->1.
    step(1'b0, 1'b1, 4, 3, 0, 1, 2, 3, "R4 merge 4,3");
    step(1'b0, 1'b0, 0, 0, 4, 3, 2, 1, "R9 lookup after merge 4,3");
    step(1'b0, 1'b1, 3, 2, 4, 3, 2, 1, "R4 merge 3,2");
    step(1'b0, 1'b1, 2, 1, 4, 3, 2, 1, "R9 merge 2,1");
    step(1'b0, 1'b0, 0, 0, 4, 3, 2, 1, "R4 chain to root 1");
    look_all("R4 full table after chain");

    // No-op merge, done still pulses.
    step(1'b0, 1'b1, 3, 4, 4, 3, 1, 0, "R6 merge shared root");
    look_all("R6 table unchanged / R7 done");

    // Swapped operands.
    step(1'b0, 1'b1, 7, 5, 5, 6, 7, 0, "R5 merge 7,5");
    look_all("R5 after 7,5");
    step(1'b0, 1'b1, 6, 7, 5, 6, 7, 1, "R4 merge 6,7 roots 6,5");
    look_all("R10 after 6,7");
    step(1'b0, 1'b1, 5, 1, 5, 6, 7, 2, "R4 merge 5,1");
    step(1'b0, 1'b0, 0, 0, 5, 6, 7, 4, "R9 lookup after 5,1");
    look_all("R10 gathered");

    // Init collides with merge.
    step(1'b1, 1'b1, 0, 0, 1, 2, 3, 4, "R8 init with merge");
    look_all("R2 identity after init / R8 no done");

    // Same merges in reverse operand order give the same table.
    step(1'b0, 1'b1, 5, 7, 7, 5, 0, 0, "R5 merge 5,7");
    look_all("R5 after 5,7");
    step(1'b0, 1'b1, 6, 6, 6, 6, 0, 0, "R6 self merge");
    look_all("R7 done after self merge");
    step(1'b1, 1'b0, 0, 0, 7, 6, 5, 4, "R2 init alone");
    look_all("R2 identity");
    step(1'b0, 1'b0, 0, 0, 0, 0, 0, 0, "R7 idle no done");
    repeat (3) @(posedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule